// File: doc/BRIEF.md
# Associative Result Reduction Tree

This block merges the per-cluster results of an associative search into a single answer for the module controller. Every leaf cluster delivers three things: a partial sum from its local compute kernel, a count of matching rows, and the index of its first matching row qualified by a hit flag. A pipelined tree of four-input nodes combines these level by level. Each node works out three reductions at once: a fixed-width sum, a widened population count, and a priority pick of the first child that reports a hit, with that child's 2-bit number placed above the child's index.

The sum keeps a fixed width at every level. Each node checks whether its four-way addition overflowed, reading the operands as signed or unsigned according to a mode bit. A flag raised at any node travels to the root. At the root, a sticky flag records that an overflow occurred and holds until the controller clears it. Valid, mode and overflow move with the data through the pipeline, so a new set of leaf results can enter on every cycle.

Top module: `assoc_reduce_tree`

## Requirements
- R1: `out_sum` equals the sum of all `LEAVES` leaf sums modulo 2^SUM_W. Leaf j occupies bits [j*SUM_W +: SUM_W] of `leaf_sum`.
- R2: `out_cnt` equals the exact total of all leaf counts. It is CNT_W+2*LEVELS bits wide and never wraps. Leaf j occupies bits [j*CNT_W +: CNT_W].
- R3: `out_hit` is high when any bit of `leaf_hit` is high. `out_idx` then equals j*2^IDX_W + (index of leaf j), where j is the lowest-numbered leaf with its hit bit set. In that value the leaf's index sits in the low IDX_W bits, and above it the 2-bit child numbers are stacked, with the root's child number on top.
- R4: When no bit of `leaf_hit` is set, `out_hit` is 0 and `out_idx` is 0.
- R5: With `signed_mode`=0, `out_ovf` is 1 exactly when the unsigned sum of the leaf sums exceeds 2^SUM_W-1.
- R6: With `signed_mode`=1, each node reads its four operands as two's complement. `out_ovf` is 1 when any node's four-way sum falls outside [-2^(SUM_W-1), 2^(SUM_W-1)-1], even if the final total is back in range.
- R7: Every cycle with `in_valid`=1 produces exactly one cycle of `out_valid`=1, exactly LEVELS clock edges later. Inputs may be applied back to back. Results follow the order in which they entered. The mode bit travels with its vector.
- R8: `ovf_sticky` rises one edge after a cycle with `out_valid`=1 and `out_ovf`=1, and then holds. A cycle with `ovf_clear`=1 clears it one edge later, but a new overflow arriving in the same cycle wins and keeps it set.
- R9: While reset is applied, and in the cycles right after it, `out_valid` and `ovf_sticky` read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| signed_mode | input | 1 | 1: sums read as two's complement for overflow; 0: unsigned |
| in_valid | input | 1 | Leaf results on the inputs are valid this cycle |
| leaf_sum | input | LEAVES*SUM_W | Partial sums, leaf j in slice j |
| leaf_cnt | input | LEAVES*CNT_W | Match counts, leaf j in slice j |
| leaf_idx | input | LEAVES*IDX_W | First-match row index per leaf |
| leaf_hit | input | LEAVES | Per-leaf first-match index valid |
| ovf_clear | input | 1 | Clears the sticky overflow flag |
| out_valid | output | 1 | Root results valid |
| out_sum | output | SUM_W | Total sum |
| out_cnt | output | CNT_W+2*LEVELS | Total match count |
| out_idx | output | IDX_W+2*LEVELS | Global first-match index |
| out_hit | output | 1 | Some leaf reported a match |
| out_ovf | output | 1 | Overflow in this result's summation |
| ovf_sticky | output | 1 | Overflow seen since the last clear |

## Verification
The root results and `out_valid` for a vector are due LEVELS edges after the edge that captures it. `ovf_sticky` follows one edge after that. The bench stamps each vector with the cycle number in which it was driven and queues its arithmetic expectation. When `out_valid` is seen, sampled on the falling edge, the bench compares the current cycle with the stamp plus LEVELS, and reports any stamp whose cycle passes without a result. The sticky-flag checks count the same way: one extra edge after the overflowing result, and one edge after a clear pulse.

// File: rtl/arrt_node.sv
module arrt_node #(
  parameter int SUM_W = 16,
  parameter int CNT_W = 4,
  parameter int IDX_W = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_in,
  input  logic                 in_valid,
  input  logic [4*SUM_W-1:0]   c_sum,
  input  logic [4*CNT_W-1:0]   c_cnt,
  input  logic [4*IDX_W-1:0]   c_idx,
  input  logic [3:0]           c_hit,
  input  logic [3:0]           c_ovf,
  output logic                 out_valid,
  output logic [SUM_W-1:0]     out_sum,
  output logic [CNT_W+1:0]     out_cnt,
  output logic [IDX_W+1:0]     out_idx,
  output logic                 out_hit,
  output logic                 out_ovf
);
  localparam int EXT_W  = SUM_W + 2;
  localparam int OCNT_W = CNT_W + 2;
  localparam int OIDX_W = IDX_W + 2;

  logic [SUM_W-1:0]  part;
  logic [EXT_W-1:0]  sum_ext;
  logic [2:0]        top_bits;
  logic              local_ovf;
  logic [OCNT_W-1:0] cnt_n;
  logic [OIDX_W-1:0] idx_n;
  logic              hit_n;
  logic              ovf_n;

  // Three reductions computed side by side
  always_comb begin
    part    = '0;
    sum_ext = '0;
    cnt_n   = '0;
    idx_n   = '0;
    for (int k = 0; k < 4; k++) begin
      part    = c_sum[k*SUM_W +: SUM_W];
      sum_ext = sum_ext + (mode_in ? {{2{part[SUM_W-1]}}, part} : {2'b00, part});
      cnt_n   = cnt_n + OCNT_W'(c_cnt[k*CNT_W +: CNT_W]);
    end
    // Lowest-numbered hitting child wins: scan downward, last write stands
    for (int k = 3; k >= 0; k--) begin
      if (c_hit[k]) idx_n = {2'(k), c_idx[k*IDX_W +: IDX_W]};
    end
    hit_n     = |c_hit;
    top_bits  = sum_ext[EXT_W-1:SUM_W-1];
    local_ovf = mode_in ? ((|top_bits) && !(&top_bits))
                        : (|sum_ext[EXT_W-1:SUM_W]);
    ovf_n     = local_ovf | (|c_ovf);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= in_valid;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sum <= '0;
      out_cnt <= '0;
      out_idx <= '0;
      out_hit <= 1'b0;
      out_ovf <= 1'b0;
    end else if (in_valid) begin
      out_sum <= sum_ext[SUM_W-1:0];
      out_cnt <= cnt_n;
      out_idx <= idx_n;
      out_hit <= hit_n;
      out_ovf <= ovf_n;
    end
  end

  assert_valid_follow_R7: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_idx_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_hit) |-> (out_idx == '0));
  assert_ovf_carry_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (|c_ovf)) |=> out_ovf);
  assert_hit_carry_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && (|c_hit)) |=> out_hit);
endmodule

// File: rtl/arrt_ovf_flag.sv
module arrt_ovf_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  logic flag_n;

  always_comb begin
    flag_n = set | (flag & ~clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= flag_n;
  end

  assert_sticky_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag);
  assert_sticky_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag);
  assert_sticky_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !set) |=> !flag);
endmodule

// File: rtl/assoc_reduce_tree.sv
module assoc_reduce_tree #(
  parameter int LEVELS = 2,
  parameter int SUM_W  = 16,
  parameter int CNT_W  = 4,
  parameter int IDX_W  = 3,
  localparam int LEAVES = 4**LEVELS,
  localparam int RCNT_W = CNT_W + 2*LEVELS,
  localparam int RIDX_W = IDX_W + 2*LEVELS
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    signed_mode,
  input  logic                    in_valid,
  input  logic [LEAVES*SUM_W-1:0] leaf_sum,
  input  logic [LEAVES*CNT_W-1:0] leaf_cnt,
  input  logic [LEAVES*IDX_W-1:0] leaf_idx,
  input  logic [LEAVES-1:0]       leaf_hit,
  input  logic                    ovf_clear,
  output logic                    out_valid,
  output logic [SUM_W-1:0]        out_sum,
  output logic [RCNT_W-1:0]       out_cnt,
  output logic [RIDX_W-1:0]       out_idx,
  output logic                    out_hit,
  output logic                    out_ovf,
  output logic                    ovf_sticky
);
  logic [1:0] rst_sync;
  logic       rst_int;

  // Asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_int = rst_sync[1];

  for (genvar l = 0; l < LEVELS; l++) begin : g_lvl
    localparam int NIN  = 4**(LEVELS-l);
    localparam int NOUT = NIN/4;
    localparam int CW   = CNT_W + 2*l;
    localparam int IW   = IDX_W + 2*l;

    logic [NIN*SUM_W-1:0]     s_in;
    logic [NIN*CW-1:0]        c_in;
    logic [NIN*IW-1:0]        i_in;
    logic [NIN-1:0]           h_in;
    logic [NIN-1:0]           o_in;
    logic                     v_in;
    logic                     m_in;
    logic [NOUT*SUM_W-1:0]    s_out;
    logic [NOUT*(CW+2)-1:0]   c_out;
    logic [NOUT*(IW+2)-1:0]   i_out;
    logic [NOUT-1:0]          h_out;
    logic [NOUT-1:0]          o_out;
    logic [NOUT-1:0]          v_out;
    logic                     v_lvl;

    assign v_lvl = |v_out;

    if (l == 0) begin : g_src
      assign s_in = leaf_sum;
      assign c_in = leaf_cnt;
      assign i_in = leaf_idx;
      assign h_in = leaf_hit;
      assign o_in = '0;
      assign v_in = in_valid;
      assign m_in = signed_mode;
    end else begin : g_chain
      logic m_q;
      // mode travels one stage per level alongside the data
      always_ff @(posedge clk or negedge rst_int) begin
        if (!rst_int) m_q <= 1'b0;
        else          m_q <= g_lvl[l-1].m_in;
      end
      assign s_in = g_lvl[l-1].s_out;
      assign c_in = g_lvl[l-1].c_out;
      assign i_in = g_lvl[l-1].i_out;
      assign h_in = g_lvl[l-1].h_out;
      assign o_in = g_lvl[l-1].o_out;
      assign v_in = g_lvl[l-1].v_lvl;
      assign m_in = m_q;
    end

    for (genvar n = 0; n < NOUT; n++) begin : g_node
      arrt_node #(.SUM_W(SUM_W), .CNT_W(CW), .IDX_W(IW)) u_node (
        .clk       (clk),
        .rst_n     (rst_int),
        .mode_in   (m_in),
        .in_valid  (v_in),
        .c_sum     (s_in[n*4*SUM_W +: 4*SUM_W]),
        .c_cnt     (c_in[n*4*CW +: 4*CW]),
        .c_idx     (i_in[n*4*IW +: 4*IW]),
        .c_hit     (h_in[n*4 +: 4]),
        .c_ovf     (o_in[n*4 +: 4]),
        .out_valid (v_out[n]),
        .out_sum   (s_out[n*SUM_W +: SUM_W]),
        .out_cnt   (c_out[n*(CW+2) +: CW+2]),
        .out_idx   (i_out[n*(IW+2) +: IW+2]),
        .out_hit   (h_out[n]),
        .out_ovf   (o_out[n])
      );
    end
  end

  assign out_valid = g_lvl[LEVELS-1].v_lvl;
  assign out_sum   = g_lvl[LEVELS-1].s_out;
  assign out_cnt   = g_lvl[LEVELS-1].c_out;
  assign out_idx   = g_lvl[LEVELS-1].i_out;
  assign out_hit   = g_lvl[LEVELS-1].h_out[0];
  assign out_ovf   = g_lvl[LEVELS-1].o_out[0];

  arrt_ovf_flag u_flag (
    .clk   (clk),
    .rst_n (rst_int),
    .set   (out_valid & out_ovf),
    .clr   (ovf_clear),
    .flag  (ovf_sticky)
  );
endmodule

// File: tb/assoc_reduce_tree_tb_top.sv
module assoc_reduce_tree_tb_top;
  localparam int LEVELS = 2;
  localparam int SUM_W  = 8;
  localparam int CNT_W  = 3;
  localparam int IDX_W  = 2;
  localparam int LEAVES = 4**LEVELS;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic signed_mode = 1'b0;
  logic in_valid = 1'b0;
  logic ovf_clear = 1'b0;
  logic [LEAVES*SUM_W-1:0] leaf_sum = '0;
  logic [LEAVES*CNT_W-1:0] leaf_cnt = '0;
  logic [LEAVES*IDX_W-1:0] leaf_idx = '0;
  logic [LEAVES-1:0]       leaf_hit = '0;
  logic                    out_valid, out_hit, out_ovf, ovf_sticky;
  logic [SUM_W-1:0]        out_sum;
  logic [CNT_W+2*LEVELS-1:0] out_cnt;
  logic [IDX_W+2*LEVELS-1:0] out_idx;

  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit mon_on = 1'b0;
  int q_cyc[$], q_sum[$], q_cnt[$], q_idx[$], q_hit[$], q_ovf[$];

  always #5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  assoc_reduce_tree #(.LEVELS(LEVELS), .SUM_W(SUM_W), .CNT_W(CNT_W), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .signed_mode(signed_mode), .in_valid(in_valid),
    .leaf_sum(leaf_sum), .leaf_cnt(leaf_cnt), .leaf_idx(leaf_idx), .leaf_hit(leaf_hit),
    .ovf_clear(ovf_clear), .out_valid(out_valid), .out_sum(out_sum), .out_cnt(out_cnt),
    .out_idx(out_idx), .out_hit(out_hit), .out_ovf(out_ovf), .ovf_sticky(ovf_sticky)
  );

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // kind 0: small values, 1: all 0xFF, 2: all 0x7F, 3: 0x7F x4 then 0x80 x4
  task automatic drive_vec(logic [LEAVES-1:0] hits, bit mode, int kind);
    int v[LEAVES];
    int n, t, ovf, cnt_tot, idx_e, hit_e;
    logic [SUM_W-1:0] s;
    logic [CNT_W-1:0] c;
    logic [IDX_W-1:0] ix;
    ovf = 0; cnt_tot = 0; idx_e = 0; hit_e = 0;
    for (int j = 0; j < LEAVES; j++) begin
      case (kind)
        1: s = 8'hFF;
        2: s = 8'h7F;
        3: s = (j < 4) ? 8'h7F : ((j < 8) ? 8'h80 : 8'h00);
        default: s = mode ? 8'(($urandom % 16) - 8) : 8'($urandom % 16);
      endcase
      c  = 3'($urandom);
      ix = 2'($urandom);
      leaf_sum[j*SUM_W +: SUM_W] = s;
      leaf_cnt[j*CNT_W +: CNT_W] = c;
      leaf_idx[j*IDX_W +: IDX_W] = ix;
      v[j] = int'(s);
      if (mode && s[SUM_W-1]) v[j] = v[j] - 256;
      cnt_tot += int'(c);
      if (hits[j] && !hit_e) begin
        hit_e = 1;
        idx_e = j * (1 << IDX_W) + int'(ix);
      end
    end
    n = LEAVES;
    while (n > 1) begin
      for (int k = 0; k < n/4; k++) begin
        t = v[4*k] + v[4*k+1] + v[4*k+2] + v[4*k+3];
        if (mode ? (t < -128 || t > 127) : (t > 255)) ovf = 1;
        t = t & 255;
        if (mode && t >= 128) t = t - 256;
        v[k] = t;
      end
      n = n / 4;
    end
    leaf_hit    = hits;
    signed_mode = mode;
    in_valid    = 1'b1;
    q_cyc.push_back(cyc + LEVELS);
    q_sum.push_back(v[0] & 255);
    q_cnt.push_back(cnt_tot);
    q_idx.push_back(idx_e);
    q_hit.push_back(hit_e);
    q_ovf.push_back(ovf);
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  always @(negedge clk) begin
    if (mon_on) begin
      if (out_valid) begin
        if (q_cyc.size() == 0) chk("R7 unexpected out_valid", 1, 0);
        else begin
          chk("R7 latency", cyc, q_cyc.pop_front());
          chk("R1 sum", int'(out_sum), q_sum.pop_front());
          chk("R2 count", int'(out_cnt), q_cnt.pop_front());
          chk("R3 hit", int'(out_hit), q_hit[0]);
          if (q_hit.pop_front() != 0) chk("R3 index", int'(out_idx), q_idx.pop_front());
          else chk("R4 index when no hit", int'(out_idx), q_idx.pop_front());
          chk("R5/R6 overflow", int'(out_ovf), q_ovf.pop_front());
        end
      end else if (q_cyc.size() > 0 && q_cyc[0] <= cyc) begin
        chk("R7 missing out_valid", 0, 1);
        void'(q_cyc.pop_front()); void'(q_sum.pop_front()); void'(q_cnt.pop_front());
        void'(q_idx.pop_front()); void'(q_hit.pop_front()); void'(q_ovf.pop_front());
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    chk("R9 out_valid in reset", int'(out_valid), 0);
    chk("R9 sticky in reset", int'(ovf_sticky), 0);
    @(posedge clk); #1 rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 out_valid after release", int'(out_valid), 0);
    chk("R9 sticky after release", int'(ovf_sticky), 0);
    mon_on = 1'b1;

    // R1-R4, R7: every hit pattern, back to back, with occasional gaps
    for (int p = 0; p < (1 << LEAVES); p++) begin
      step();
      drive_vec(LEAVES'(p), 1'($urandom), 0);
      if (p % 97 == 3) begin
        step();
        in_valid = 1'b0;
      end
    end
    step(); in_valid = 1'b0;
    repeat (LEVELS + 2) step();
    @(negedge clk);
    chk("R8 sticky stays clear without overflow", int'(ovf_sticky), 0);

    // R5: unsigned overflow, then sticky set (R8)
    step(); drive_vec(16'h0100, 1'b0, 1);
    step(); in_valid = 1'b0;
    repeat (LEVELS) step();
    @(negedge clk);
    chk("R8 sticky set after overflow", int'(ovf_sticky), 1);
    for (int k = 0; k < 5; k++) begin
      step(); drive_vec(LEAVES'($urandom), 1'b0, 0);
    end
    step(); in_valid = 1'b0;
    repeat (LEVELS) step();
    @(negedge clk);
    chk("R8 sticky holds", int'(ovf_sticky), 1);
    step(); ovf_clear = 1'b1;
    step(); ovf_clear = 1'b0;
    @(negedge clk);
    chk("R8 sticky cleared", int'(ovf_sticky), 0);

    // R6: all -1 in signed mode is in range
    step(); drive_vec(16'h8000, 1'b1, 1);
    step(); in_valid = 1'b0;
    repeat (LEVELS) step();
    @(negedge clk);
    chk("R6 no sticky for in-range signed", int'(ovf_sticky), 0);

    // R6 overflow; R8 set wins over a simultaneous clear
    step(); drive_vec(16'h0000, 1'b1, 2);
    step(); in_valid = 1'b0;
    step(); ovf_clear = 1'b1;
    step(); ovf_clear = 1'b0;
    @(negedge clk);
    chk("R8 set wins over clear", int'(ovf_sticky), 1);
    step(); ovf_clear = 1'b1;
    step(); ovf_clear = 1'b0;
    @(negedge clk);
    chk("R8 sticky cleared again", int'(ovf_sticky), 0);

    // R6: intermediate node overflow while the total is back in range
    step(); drive_vec(16'h0030, 1'b1, 3);
    step(); in_valid = 1'b0;
    repeat (LEVELS) step();
    @(negedge clk);
    chk("R6 sticky from intermediate overflow", int'(ovf_sticky), 1);

    repeat (4) step();
    chk("R7 all results delivered", q_cyc.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule